// File: doc/BRIEF.md
# Quad-IO Flash Command Sequencer

This block is the host side of a serial NOR flash link that runs every phase of a command on four data lines at single data rate. A client hands it one operation at a time: an opcode, a start address, a byte count, and the settings for address width, program buffer size, dummy length and chip-select spacing. The sequencer builds the chip-select frames, produces the serial clock at half the system clock rate, and moves each byte over the four lines as two nibbles.

A program request creates two frames. The first carries only the write-enable opcode. The second carries the program opcode, the start address and then the bytes taken from the write stream. Each byte goes to the next address, so no further address is sent. A read request creates one frame: the opcode, the address, a set number of dummy clocks with the output drivers released, and then as many bytes as requested, each delivered on the read stream. The frame ends only when the count is reached and chip select rises.

If either stream is not ready, the serial clock is held at its present level until the stream can proceed. A request with an unknown opcode or a bad byte count is refused with a one-cycle error pulse, and no frame is sent.

Top module: `quad_flash_seq`

## Requirements
- R1: Opcode, address and data bytes are sent on io_o[3:0], high nibble first, one nibble per serial clock period. io_o changes only while sclk_o is low, and it holds steady through each high phase.
- R2: A program request is sent as two frames. First comes a frame that holds only opcode 0x06 (two nibbles). Then comes the program frame.
- R3: The address width depends on the opcode. With 0x02 or 0xEB it is 3 bytes when cfg_addr4_i is 0 and 4 bytes when cfg_addr4_i is 1. With 0x12, 0x0C or 0xEC it is always 4 bytes. A 3-byte address sends bits 23..0.
- R4: A program frame is the opcode, then the start address, then exactly req_len_i bytes taken in order from the write stream. No second address is sent.
- R5: A request is refused when any of these holds: the opcode is not one of 0x02, 0x12, 0xEB, 0x0C or 0xEC; the length is 0; or a program length is above 256 (cfg_big_buf_i=0) or above 512 (cfg_big_buf_i=1). A refused request gives a one-cycle err_o pulse, sends no frame and leaves req_ready_o high.
- R6: A read frame puts cfg_dummy_i serial clocks between the last address nibble and the first data nibble. io_oe_o is 0 from the start of the dummy phase (or of the data phase, when there are no dummy clocks) until the frame ends.
- R7: A read returns exactly req_len_i bytes on the read stream. Byte k holds the flash contents at start address + k. Chip select rises after the last byte.
- R8: While rd_valid_o is high and rd_ready_i is low, rd_data_o holds steady and no read byte is lost. The serial clock pauses.
- R9: While a program frame waits for write data, the serial clock pauses. Bytes arriving with gaps are still sent in order.
- R10: Between two frames, cs_n_o stays high for at least max(cfg_gap_i, 1) clock cycles.
- R11: done_o pulses for one cycle, in the same cycle that cs_n_o rises at the end of the last frame of a request. req_ready_o is low from acceptance until the spacing after that frame has passed.
- R12: After reset, cs_n_o=1, sclk_o=0, io_oe_o=0, rd_valid_o=0, done_o=0, err_o=0 and req_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_addr4_i | input | 1 | 4-byte address select for 0x02 and 0xEB |
| cfg_big_buf_i | input | 1 | Program buffer 512 bytes when 1, 256 bytes when 0 |
| cfg_dummy_i | input | DUM_W | Dummy clocks after a read address |
| cfg_gap_i | input | GAP_W | Minimum chip-select high cycles between frames |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_opcode_i | input | 8 | Command opcode |
| req_addr_i | input | 32 | Start address |
| req_len_i | input | LEN_W | Byte count |
| err_o | output | 1 | Request refused (pulse) |
| done_o | output | 1 | Request finished (pulse) |
| wr_valid_i | input | 1 | Program byte valid |
| wr_ready_o | output | 1 | Program byte taken |
| wr_data_i | input | 8 | Program byte |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Read byte accepted |
| rd_data_o | output | 8 | Read byte |
| cs_n_o | output | 1 | Flash chip select, active low |
| sclk_o | output | 1 | Serial clock |
| io_o | output | 4 | IO line drive values |
| io_oe_o | output | 4 | IO line output enables |
| io_i | input | 4 | IO line input values |

## Verification
Two things can happen in the same cycle in a read frame. The byte just completed on the serial lines can be written into the read holding register, and the consumer can take the byte already held there. The bench provokes this by pulsing rd_ready_i once every four cycles during a long read, so the clock edge that completes a byte sometimes lands on an accept and sometimes on a held byte. Each case is judged by comparing every received byte, and the total count, against the flash model's contents for consecutive addresses. A parked clock and an overwrite leave different traces in that comparison.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_WREN, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA
  } seq_st_e;

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_PROG3  = 8'h02;
  localparam logic [7:0] OPC_PROG4  = 8'h12;
  localparam logic [7:0] OPC_RD_A   = 8'hEB;
  localparam logic [7:0] OPC_RD_B   = 8'h0C;
  localparam logic [7:0] OPC_RD_C   = 8'hEC;

  typedef struct packed {
    logic ok;
    logic prog;
    logic wide;
  } op_info_t;
endpackage

// File: rtl/qfs_decode.sv
module qfs_decode
  import qfs_pkg::*;
#(
  parameter int LEN_W      = 20,
  parameter int PAGE_BYTES = 256
) (
  input  logic [7:0]       opcode_i,
  input  logic             addr4_i,
  input  logic             big_buf_i,
  input  logic [LEN_W-1:0] len_i,
  output op_info_t         info_o
);
  localparam logic [LEN_W-1:0] CAP_S = LEN_W'(PAGE_BYTES);
  localparam logic [LEN_W-1:0] CAP_L = LEN_W'(2 * PAGE_BYTES);

  logic op_known;
  logic [LEN_W-1:0] cap;

  always_comb begin
    op_known = 1'b1;
    info_o   = '0;
    unique case (opcode_i)
      OPC_PROG3: begin info_o.prog = 1'b1; info_o.wide = addr4_i; end
      OPC_PROG4: begin info_o.prog = 1'b1; info_o.wide = 1'b1;    end
      OPC_RD_A:  info_o.wide = addr4_i;
      OPC_RD_B,
      OPC_RD_C:  info_o.wide = 1'b1;
      default:   op_known = 1'b0;
    endcase
    cap       = big_buf_i ? CAP_L : CAP_S;
    info_o.ok = op_known && (len_i != '0) && (!info_o.prog || len_i <= cap);
  end
endmodule

// File: rtl/qfs_rd_buf.sv
module qfs_rd_buf #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (push_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // slot cannot take a new byte this cycle
  assign full_o = valid_o && !ready_i;
endmodule

// File: rtl/qfs_seq.sv
module qfs_seq
  import qfs_pkg::*;
#(
  parameter int LEN_W = 20,
  parameter int DUM_W = 4,
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  op_info_t         info_i,
  input  logic [7:0]       req_opcode_i,
  input  logic [31:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [DUM_W-1:0] cfg_dummy_i,
  input  logic [GAP_W-1:0] cfg_gap_i,
  input  logic             wr_valid_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_full_i,
  input  logic [3:0]       io_i,
  output logic             req_ready_o,
  output logic             err_o,
  output logic             done_o,
  output logic             wr_ready_o,
  output logic             rd_push_o,
  output logic [7:0]       rd_byte_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [3:0]       io_o,
  output logic             oe_o
);
  localparam int CNT_W = (DUM_W > 3) ? DUM_W : 3;

  seq_st_e          st_q;
  logic             prog_q, wide_q, to_cmd_q;
  logic [7:0]       opc_q;
  logic [31:0]      addr_q, sh_q;
  logic [LEN_W-1:0] left_q;
  logic [CNT_W-1:0] nib_q;
  logic [GAP_W-1:0] gap_q;
  logic [3:0]       hi_q;
  logic             unit_end, rd_data_ph, rd_hold;

  assign unit_end    = (nib_q == '0);
  assign rd_data_ph  = (st_q == ST_DATA) && !prog_q;
  assign rd_hold     = rd_data_ph && !sclk_o && unit_end && rd_full_i;
  assign rd_push_o   = rd_data_ph && !sclk_o && unit_end && !rd_full_i;
  assign rd_byte_o   = {hi_q, io_i};
  assign wr_ready_o  = sclk_o && prog_q && unit_end &&
                       ((st_q == ST_ADDR) || (st_q == ST_DATA && left_q != LEN_W'(1)));
  assign req_ready_o = (st_q == ST_IDLE);
  assign io_o        = sh_q[31:28];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  sclk_o <= 1'b0; cs_n_o <= 1'b1; oe_o <= 1'b0;
      done_o <= 1'b0;   err_o <= 1'b0;  prog_q <= 1'b0; wide_q <= 1'b0;
      to_cmd_q <= 1'b0; opc_q <= '0;    addr_q <= '0;   sh_q <= '0;
      left_q <= '0;     nib_q <= '0;    gap_q <= '0;    hi_q <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          if (!info_i.ok) begin
            err_o <= 1'b1;
          end else begin
            opc_q  <= req_opcode_i; addr_q <= req_addr_i; left_q <= req_len_i;
            prog_q <= info_i.prog;  wide_q <= info_i.wide;
            cs_n_o <= 1'b0; oe_o <= 1'b1; nib_q <= CNT_W'(1);
            sh_q   <= {(info_i.prog ? OPC_WREN : req_opcode_i), 24'h0};
            st_q   <= info_i.prog ? ST_WREN : ST_CMD;
          end
        end
        ST_GAP: begin
          if (gap_q >= cfg_gap_i) begin
            if (to_cmd_q) begin
              to_cmd_q <= 1'b0; cs_n_o <= 1'b0; oe_o <= 1'b1;
              sh_q <= {opc_q, 24'h0}; nib_q <= CNT_W'(1); st_q <= ST_CMD;
            end else begin
              st_q <= ST_IDLE;
            end
          end else begin
            gap_q <= gap_q + GAP_W'(1);
          end
        end
        default: begin
          if (!sclk_o) begin
            // rising edge: flash samples, read data captured here
            if (!rd_hold) begin
              sclk_o <= 1'b1;
              if (rd_data_ph && !unit_end) hi_q <= io_i;
            end
          end else if (!unit_end) begin
            sclk_o <= 1'b0;
            sh_q   <= sh_q << 4;
            nib_q  <= nib_q - CNT_W'(1);
          end else begin
            unique case (st_q)
              ST_WREN: begin
                to_cmd_q <= 1'b1; cs_n_o <= 1'b1; sclk_o <= 1'b0; oe_o <= 1'b0;
                gap_q <= GAP_W'(1); st_q <= ST_GAP;
              end
              ST_CMD: begin
                sclk_o <= 1'b0; st_q <= ST_ADDR;
                sh_q   <= wide_q ? addr_q : {addr_q[23:0], 8'h0};
                nib_q  <= wide_q ? CNT_W'(7) : CNT_W'(5);
              end
              ST_ADDR: begin
                if (prog_q) begin
                  if (wr_valid_i) begin
                    sclk_o <= 1'b0; sh_q <= {wr_data_i, 24'h0};
                    nib_q <= CNT_W'(1); st_q <= ST_DATA;
                  end
                end else begin
                  sclk_o <= 1'b0; oe_o <= 1'b0;
                  if (cfg_dummy_i != '0) begin
                    st_q  <= ST_DUMMY;
                    nib_q <= CNT_W'(cfg_dummy_i - DUM_W'(1));
                  end else begin
                    st_q  <= ST_DATA;
                    nib_q <= CNT_W'(1);
                  end
                end
              end
              ST_DUMMY: begin
                sclk_o <= 1'b0; st_q <= ST_DATA; nib_q <= CNT_W'(1);
              end
              default: begin
                if (left_q == LEN_W'(1)) begin
                  cs_n_o <= 1'b1; sclk_o <= 1'b0; oe_o <= 1'b0; done_o <= 1'b1;
                  gap_q <= GAP_W'(1); st_q <= ST_GAP;
                end else if (!prog_q || wr_valid_i) begin
                  sclk_o <= 1'b0; nib_q <= CNT_W'(1);
                  left_q <= left_q - LEN_W'(1);
                  if (prog_q) sh_q <= {wr_data_i, 24'h0};
                end
              end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/quad_flash_seq.sv
module quad_flash_seq
  import qfs_pkg::*;
#(
  parameter int LEN_W      = 20,
  parameter int DUM_W      = 4,
  parameter int GAP_W      = 4,
  parameter int PAGE_BYTES = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_addr4_i,
  input  logic             cfg_big_buf_i,
  input  logic [DUM_W-1:0] cfg_dummy_i,
  input  logic [GAP_W-1:0] cfg_gap_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [7:0]       req_opcode_i,
  input  logic [31:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             err_o,
  output logic             done_o,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [7:0]       wr_data_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [7:0]       rd_data_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [3:0]       io_o,
  output logic [3:0]       io_oe_o,
  input  logic [3:0]       io_i
);
  op_info_t   info;
  logic       rd_full, rd_push, oe;
  logic [7:0] rd_byte;

  qfs_decode #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_dec (
    .opcode_i(req_opcode_i), .addr4_i(cfg_addr4_i), .big_buf_i(cfg_big_buf_i),
    .len_i(req_len_i), .info_o(info)
  );

  qfs_seq #(.LEN_W(LEN_W), .DUM_W(DUM_W), .GAP_W(GAP_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .info_i(info), .req_opcode_i, .req_addr_i,
    .req_len_i, .cfg_dummy_i, .cfg_gap_i, .wr_valid_i, .wr_data_i,
    .rd_full_i(rd_full), .io_i, .req_ready_o, .err_o, .done_o, .wr_ready_o,
    .rd_push_o(rd_push), .rd_byte_o(rd_byte), .cs_n_o, .sclk_o, .io_o, .oe_o(oe)
  );

  qfs_rd_buf #(.W(8)) u_rdb (
    .clk_i, .rst_ni, .push_i(rd_push), .data_i(rd_byte), .ready_i(rd_ready_i),
    .valid_o(rd_valid_o), .data_o(rd_data_o), .full_o(rd_full)
  );

  assign io_oe_o = {4{oe}};
endmodule

// File: rtl/qfs_chk.sv
module qfs_chk #(
  parameter int GAP_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [GAP_W-1:0] cfg_gap_i,
  input logic             req_ready_o,
  input logic             err_o,
  input logic             done_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic [7:0]       rd_data_o,
  input logic             cs_n_o,
  input logic             sclk_o,
  input logic [3:0]       io_o,
  input logic [3:0]       io_oe_o
);
  logic [GAP_W:0] hi_cnt_q;
  logic           seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (!cs_n_o) seen_q <= 1'b1;
      if (!cs_n_o) hi_cnt_q <= '0;
      else if (hi_cnt_q != '1) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assert_io_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(io_o));

  assert_err_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_n_o && req_ready_o));

  assert_err_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  assert_rd_released_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> (io_oe_o == 4'h0));

  assert_rd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  assert_cs_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_n_o) && seen_q) |-> (hi_cnt_q != '0 && hi_cnt_q >= {1'b0, cfg_gap_i}));

  assert_done_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && !$past(cs_n_o)));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !req_ready_o);
endmodule

bind quad_flash_seq qfs_chk #(.GAP_W(GAP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_gap_i(cfg_gap_i), .req_ready_o(req_ready_o),
  .err_o(err_o), .done_o(done_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_data_o(rd_data_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .io_o(io_o),
  .io_oe_o(io_oe_o)
);

// File: tb/sim_quad_flash_seq.sv
module sim_quad_flash_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 20;
  localparam int NV = 13;
  // {opcode, addr, len[11:0], addr4, big, dummy[3:0], expect_err}
  localparam logic [58:0] VEC [NV] = '{
    {8'h02, 32'h0012_3456, 12'd4,   1'b0, 1'b0, 4'd6, 1'b0},
    {8'h02, 32'h8A12_3450, 12'd3,   1'b1, 1'b0, 4'd6, 1'b0},
    {8'h12, 32'h0000_0010, 12'd2,   1'b0, 1'b0, 4'd6, 1'b0},
    {8'hEB, 32'h0000_1000, 12'd5,   1'b0, 1'b0, 4'd6, 1'b0},
    {8'hEB, 32'h0100_0FFE, 12'd4,   1'b1, 1'b0, 4'd4, 1'b0},
    {8'h0C, 32'h0000_0020, 12'd3,   1'b0, 1'b0, 4'd0, 1'b0},
    {8'hEC, 32'h0000_00FF, 12'd6,   1'b0, 1'b0, 4'd8, 1'b0},
    {8'h02, 32'h0000_0000, 12'd257, 1'b0, 1'b0, 4'd6, 1'b1},
    {8'h02, 32'h0000_0000, 12'd257, 1'b0, 1'b1, 4'd6, 1'b0},
    {8'h12, 32'h0000_0000, 12'd513, 1'b0, 1'b1, 4'd6, 1'b1},
    {8'hEB, 32'h0000_0000, 12'd0,   1'b0, 1'b0, 4'd6, 1'b1},
    {8'h9F, 32'h0000_0000, 12'd1,   1'b0, 1'b0, 4'd6, 1'b1},
    {8'h02, 32'h0000_0100, 12'd256, 1'b0, 1'b0, 4'd6, 1'b0}
  };

  logic clk = 0, rst_ni = 0;
  logic cfg_addr4 = 0, cfg_big = 0;
  logic [3:0] cfg_dummy = 4'd6, cfg_gap = 4'd2;
  logic req_valid = 0, req_ready;
  logic [7:0] req_opc = 0;
  logic [31:0] req_addr = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic err, done, wr_valid, wr_ready, rd_valid, rd_ready, cs_n, sclk;
  logic [7:0] wr_data, rd_data;
  logic [3:0] io_o, io_oe, io_i = 0;

  int checks = 0, errors = 0;
  logic [31:0] cyc = 0;
  int widx = 0, rxn = 0, done_cnt = 0, err_cnt = 0, nfr = 0, nn = 0, hic = 0, last_gap = 0;
  bit wr_en = 0, wr_thr = 0, rd_thr = 0, in_fr = 0, model_rd = 0;
  int model_start = 0;
  logic [31:0] model_addr = 0;
  logic [3:0] fnib [0:2047];
  logic [7:0] fop [0:63];
  int flen [0:63];
  logic [7:0] rxb [0:1023];

  function automatic logic [7:0] rpat(input logic [31:0] a);
    return 8'(a * 3 + (a >> 8) + 32'h1B);
  endfunction
  function automatic logic [7:0] wpat(input int i);
    return 8'(i * 29 + 7);
  endfunction

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign wr_valid = wr_en && (!wr_thr || cyc[2]);
  assign wr_data  = wpat(widx);
  assign rd_ready = !rd_thr || (cyc[1:0] == 2'b11);

  quad_flash_seq u0 (
    .clk_i(clk), .rst_ni, .cfg_addr4_i(cfg_addr4), .cfg_big_buf_i(cfg_big),
    .cfg_dummy_i(cfg_dummy), .cfg_gap_i(cfg_gap), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_opcode_i(req_opc), .req_addr_i(req_addr),
    .req_len_i(req_len), .err_o(err), .done_o(done), .wr_valid_i(wr_valid),
    .wr_ready_o(wr_ready), .wr_data_i(wr_data), .rd_valid_o(rd_valid),
    .rd_ready_i(rd_ready), .rd_data_o(rd_data), .cs_n_o(cs_n), .sclk_o(sclk),
    .io_o(io_o), .io_oe_o(io_oe), .io_i(io_i)
  );

  // stream and event bookkeeping, sampled on pre-edge values
  always @(posedge clk) begin
    if (wr_valid && wr_ready) widx <= widx + 1;
    if (rd_valid && rd_ready) begin rxb[rxn % 1024] = rd_data; rxn = rxn + 1; end
    if (done) done_cnt = done_cnt + 1;
    if (err) err_cnt = err_cnt + 1;
    if (rst_ni) begin
      if (cs_n) hic = hic + 1;
      else begin if (hic != 0) last_gap = hic; hic = 0; end
    end
  end

  // flash model
  always @(negedge cs_n) begin nn = 0; in_fr = 1; end
  always @(posedge cs_n) if (in_fr) begin
    in_fr = 0;
    if (nfr < 64) begin fop[nfr] = {fnib[0], fnib[1]}; flen[nfr] = nn; end
    nfr = nfr + 1;
  end
  always @(posedge sclk) if (in_fr && !cs_n) begin
    if (nn < 2048) fnib[nn] = io_o;
    nn = nn + 1;
  end
  always @(negedge sclk) if (in_fr && !cs_n && model_rd) begin
    int k;
    logic [7:0] b;
    k = nn - model_start;
    if (k >= 0) begin
      b = rpat(model_addr + 32'(k / 2));
      io_i = (k % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [7:0] opc, input logic [31:0] a, input int len,
                         input bit a4, input bit big, input int dum, input bit exp_err);
    bit prog, wide;
    int an, f0, d0, e0, r0, w0, bad;
    logic [31:0] got_a, exp_a;
    prog = (opc == 8'h02) || (opc == 8'h12);
    wide = (opc == 8'h12) || (opc == 8'h0C) || (opc == 8'hEC) || a4;
    an = wide ? 8 : 6;
    for (int i = 0; i < 5000 && !req_ready; i++) @(negedge clk);
    cfg_addr4 = a4; cfg_big = big; cfg_dummy = 4'(dum);
    model_rd = !prog; model_addr = a; model_start = 2 + an + dum;
    f0 = nfr; d0 = done_cnt; e0 = err_cnt; r0 = rxn; w0 = widx;
    wr_en = prog;
    req_opc = opc; req_addr = a; req_len = LEN_W'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (exp_err) begin
      repeat (3) @(negedge clk);
      chk(err_cnt == e0 + 1, "R5", "err pulse count", err_cnt - e0, 1);
      chk(nfr == f0 && req_ready, "R5", "no frame after refusal", nfr - f0, 0);
    end else begin
      chk(!req_ready, "R11", "busy after accept", req_ready, 0);
      for (int i = 0; i < 30000 && done_cnt == d0; i++) @(negedge clk);
      for (int i = 0; i < 100 && rd_valid; i++) @(negedge clk);
      chk(done_cnt == d0 + 1, "R11", "done pulses", done_cnt - d0, 1);
      chk(nfr - f0 == (prog ? 2 : 1), "R2", "frame count", nfr - f0, prog ? 2 : 1);
      if (prog) begin
        chk(fop[f0] == 8'h06 && flen[f0] == 2, "R2", "write-enable frame", {fop[f0], 8'(flen[f0])}, 16'h0602);
        chk(fop[f0+1] == opc, "R1", "program opcode", fop[f0+1], opc);
        chk(flen[f0+1] == 2 + an + 2*len, "R3", "program frame nibbles", flen[f0+1], 2 + an + 2*len);
        chk(widx - w0 == len, "R4", "bytes taken", widx - w0, len);
        bad = 0;
        for (int i = 0; i < len; i++)
          if ({fnib[2+an+2*i], fnib[3+an+2*i]} != wpat(w0 + i)) bad++;
        chk(bad == 0, "R4", "program data mismatches", bad, 0);
      end else begin
        chk(fop[f0] == opc, "R1", "read opcode", fop[f0], opc);
        chk(flen[f0] == 2 + an + dum + 2*len, "R6", "read frame clocks", flen[f0], 2 + an + dum + 2*len);
        chk(rxn - r0 == len, "R7", "read byte count", rxn - r0, len);
        bad = 0;
        for (int i = 0; i < len; i++)
          if (rxb[(r0 + i) % 1024] != rpat(a + 32'(i))) bad++;
        chk(bad == 0, "R7", "read data mismatches", bad, 0);
      end
      got_a = 0;
      for (int i = 0; i < an; i++) got_a = (got_a << 4) | 32'(fnib[2+i]);
      exp_a = wide ? a : {8'h0, a[23:0]};
      chk(got_a == exp_a, "R3", "address", got_a, exp_a);
    end
    wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && io_oe == 0 && !rd_valid && !done && !err && req_ready,
        "R12", "reset outputs", {cs_n, sclk, io_oe, rd_valid, done, err, req_ready}, 10'h201);
    rst_ni = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_req(VEC[v][58:51], VEC[v][50:19], int'(VEC[v][18:7]), VEC[v][6], VEC[v][5],
              int'(VEC[v][4:1]), VEC[v][0]);

    // R10: spacing between write-enable and program frames
    cfg_gap = 4'd7;
    run_req(8'h12, 32'h0000_4000, 3, 0, 0, 6, 0);
    chk(last_gap >= 7, "R10", "cs high cycles", last_gap, 7);
    cfg_gap = 4'd2;

    // R9: program data with gaps
    wr_thr = 1;
    run_req(8'h02, 32'h0000_0200, 12, 0, 0, 6, 0);
    wr_thr = 0;

    // R8: read consumer accepts only every fourth cycle
    rd_thr = 1;
    run_req(8'hEB, 32'h0003_0000, 40, 0, 0, 6, 0);
    rd_thr = 0;

    // R8: consumer stalls with byte held; data stable, no loss
    rd_thr = 1;
    run_req(8'h0C, 32'h0000_7777, 9, 0, 0, 2, 0);
    rd_thr = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule